// File: doc/BRIEF.md
# One-Step Timestamp Latency Adjuster

This block produces the time value that a transmit path writes into a frame when it performs one-step timestamping. It receives the 80-bit time captured when the frame passed the capture point, together with an 11-bit fixed-point latency correction. It returns the corrected value one clock later with its own valid flag. The two-step report path does not go through this block and so receives no correction.

A mode input selects how the 80-bit word is read, and it is sampled with each input word. In ordinary mode the upper 48 bits count seconds and the lower 32 bits count nanoseconds. The correction is added to the nanoseconds, and a carry goes into the seconds when the total reaches one billion. In transparent mode the word carries a correction field, with 47 bits of nanoseconds at bits 62:16 and 16 bits of fractional nanoseconds at bits 15:0. The latency value is added to that field in place, and the bits above it pass through untouched.

Top module: `ts_onestep_adjust`

## Requirements
- R1: While reset is held and after it is released with no input, `res_valid` is 0 and `res_time` is all zeros.
- R2: `res_valid` equals the value `ts_valid` had at the previous rising clock edge, and each accepted word updates `res_time` at that same edge.
- R3: In ordinary mode (`transparent`=0), when the sum is below 1,000,000,000, `res_time[31:0]` is the input nanoseconds `ts_time[31:0]` plus `lat_adj[10:3]`, and `res_time[79:32]` equals `ts_time[79:32]`.
- R4: In ordinary mode the fractional bits `lat_adj[2:0]` are dropped (rounded down) and have no effect on the result.
- R5: In ordinary mode, when the nanosecond sum is 1,000,000,000 or more, `res_time[31:0]` is the sum minus 1,000,000,000 and the seconds field is incremented by one. A sum of 999,999,999 does not roll over.
- R6: In ordinary mode, a carry into a seconds field of all ones wraps the seconds to zero.
- R7: In transparent mode (`transparent`=1), `res_time[62:0]` equals `ts_time[62:0]` plus `lat_adj` shifted left by 13 (whole nanoseconds at bits 23:16, fraction at bits 15:13), modulo 2^63.
- R8: In transparent mode, `res_time[79:63]` equals `ts_time[79:63]`.
- R9: While `ts_valid` is 0, `res_time` holds its last value whatever the other inputs do.
- R10: The mode is taken per word: two back-to-back words in different modes are each adjusted by their own rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ts_valid | input | 1 | Input word present this cycle |
| transparent | input | 1 | 1 selects the correction-field encoding, 0 the seconds/nanoseconds encoding |
| ts_time | input | 80 | Captured time or correction value |
| lat_adj | input | 11 | Latency correction: bits 10:3 nanoseconds, bits 2:0 eighths of a nanosecond |
| res_valid | output | 1 | Corrected value present this cycle |
| res_time | output | 80 | Corrected time, same encoding as the input word |

## Verification
Ordinary-mode words are applied with small nanosecond values, with sums that land just below, exactly on and well past the one-billion boundary, and with an all-ones seconds field. These patterns separate a plain add from a correct carry, an off-by-one compare, and a seconds wrap. The same nanosecond value is applied with every fractional correction bit clear and then set, which shows that the fraction is discarded in this mode. Transparent-mode words use distinctive upper bits and a field near 2^63, which expose a misplaced fraction alignment, a carry leaking into the pass-through bits, or lost upper bits. A back-to-back pair with alternating modes, followed by idle cycles with changed inputs, checks that the mode is taken per word and that the result holds.

// File: rtl/ts_adj_pkg.sv
// Package: ts_adj_pkg
// Shared encodings and default field widths for the one-step timestamp
// adjuster. Assumes the 80-bit time word layouts described in the brief.
package ts_adj_pkg;

    // Interpretation of the 80-bit time word.
    typedef enum logic {
        MODE_ORDINARY    = 1'b0,
        MODE_TRANSPARENT = 1'b1
    } ts_mode_e;

    localparam int TIME_W_DEF     = 80;
    localparam int SEC_W_DEF      = 48;
    localparam int NS_W_DEF       = 32;
    localparam int TC_NS_W_DEF    = 47;
    localparam int TC_FRAC_W_DEF  = 16;
    localparam int ADJ_W_DEF      = 11;
    localparam int ADJ_FRAC_W_DEF = 3;
    localparam int NS_PER_SEC_DEF = 1000000000;

endpackage

// File: rtl/ts_adj_ordinary.sv
// Module: ts_adj_ordinary
// Adds a whole-nanosecond correction to a seconds/nanoseconds time and
// folds a nanosecond overflow into the seconds field. Purely combinational.
// Assumes the incoming nanoseconds are already below NS_PER_SEC; the carry
// is applied at most once. Seconds wrap modulo 2^SEC_W.
module ts_adj_ordinary #(
    parameter int SEC_W      = 48,
    parameter int NS_W       = 32,
    parameter int ADJ_NS_W   = 8,
    parameter int NS_PER_SEC = 1000000000
) (
    input  logic [SEC_W-1:0]    sec_in,
    input  logic [NS_W-1:0]     ns_in,
    input  logic [ADJ_NS_W-1:0] adj_ns,
    output logic [SEC_W-1:0]    sec_out,
    output logic [NS_W-1:0]     ns_out
);
    localparam int SUM_W = NS_W + 1;
    localparam logic [SUM_W-1:0] ROLL = SUM_W'(NS_PER_SEC);

    logic [SUM_W-1:0] ns_sum;
    logic [SUM_W-1:0] ns_wrapped;
    logic             carry;

    // Sum nanoseconds and decide whether a second has been completed.
    always_comb begin
        ns_sum     = {1'b0, ns_in} + SUM_W'(adj_ns);
        carry      = (ns_sum >= ROLL);
        ns_wrapped = ns_sum - ROLL;
    end

    // Select the wrapped or plain nanoseconds and bump the seconds on carry.
    always_comb begin
        ns_out  = carry ? ns_wrapped[NS_W-1:0] : ns_sum[NS_W-1:0];
        sec_out = sec_in + SEC_W'(carry);
    end

endmodule

// File: rtl/ts_adj_transparent.sv
// Module: ts_adj_transparent
// Adds a fixed-point latency value to a correction field made of whole and
// fractional nanoseconds. The correction's fraction is aligned to the top of
// the field's fraction. Purely combinational; wraps modulo 2^FIELD_W.
module ts_adj_transparent #(
    parameter int FIELD_W = 63,
    parameter int ADJ_W   = 11,
    parameter int SHIFT   = 13
) (
    input  logic [FIELD_W-1:0] field_in,
    input  logic [ADJ_W-1:0]   adj,
    output logic [FIELD_W-1:0] field_out
);
    logic [FIELD_W-1:0] addend;

    // Align the correction and add it to the field.
    always_comb begin
        addend    = FIELD_W'(adj) << SHIFT;
        field_out = field_in + addend;
    end

endmodule

// File: rtl/ts_adj_outreg.sv
// Module: ts_adj_outreg
// Output stage: loads a data word when the strobe is high, holds it
// otherwise, and delays the strobe by one cycle. Synchronous active-low reset.
module ts_adj_outreg #(
    parameter int DATA_W = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_valid,
    input  logic [DATA_W-1:0] d,
    output logic              q_valid,
    output logic [DATA_W-1:0] q
);
    // Register the valid flag and capture data only on a valid word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q       <= '0;
        end else begin
            q_valid <= d_valid;
            if (d_valid) begin
                q <= d;
            end
        end
    end

endmodule

// File: rtl/ts_onestep_adjust.sv
// Module: ts_onestep_adjust
// Top of the one-step timestamp adjuster. Computes both encodings in
// parallel, selects by the per-word mode input and registers the result.
// Assumes ordinary-mode nanoseconds arrive below one billion.
module ts_onestep_adjust
    import ts_adj_pkg::*;
#(
    parameter int TIME_W     = TIME_W_DEF,
    parameter int SEC_W      = SEC_W_DEF,
    parameter int NS_W       = NS_W_DEF,
    parameter int TC_NS_W    = TC_NS_W_DEF,
    parameter int TC_FRAC_W  = TC_FRAC_W_DEF,
    parameter int ADJ_W      = ADJ_W_DEF,
    parameter int ADJ_FRAC_W = ADJ_FRAC_W_DEF,
    parameter int NS_PER_SEC = NS_PER_SEC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ts_valid,
    input  logic              transparent,
    input  logic [TIME_W-1:0] ts_time,
    input  logic [ADJ_W-1:0]  lat_adj,
    output logic              res_valid,
    output logic [TIME_W-1:0] res_time
);
    localparam int ADJ_NS_W   = ADJ_W - ADJ_FRAC_W;
    localparam int TC_FIELD_W = TC_NS_W + TC_FRAC_W;
    localparam int TC_UPPER_W = TIME_W - TC_FIELD_W;
    localparam int TC_SHIFT   = TC_FRAC_W - ADJ_FRAC_W;

    ts_mode_e           mode;
    logic [SEC_W-1:0]   ord_sec;
    logic [NS_W-1:0]    ord_ns;
    logic [TC_FIELD_W-1:0] tc_field;
    logic [TIME_W-1:0]  ord_word;
    logic [TIME_W-1:0]  tc_word;
    logic [TIME_W-1:0]  next_word;

    // Decode the mode input into the shared enumeration.
    always_comb mode = ts_mode_e'(transparent);

    ts_adj_ordinary #(
        .SEC_W      (SEC_W),
        .NS_W       (NS_W),
        .ADJ_NS_W   (ADJ_NS_W),
        .NS_PER_SEC (NS_PER_SEC)
    ) u_ordinary (
        .sec_in  (ts_time[NS_W +: SEC_W]),
        .ns_in   (ts_time[NS_W-1:0]),
        .adj_ns  (lat_adj[ADJ_W-1:ADJ_FRAC_W]),
        .sec_out (ord_sec),
        .ns_out  (ord_ns)
    );

    ts_adj_transparent #(
        .FIELD_W (TC_FIELD_W),
        .ADJ_W   (ADJ_W),
        .SHIFT   (TC_SHIFT)
    ) u_transparent (
        .field_in  (ts_time[TC_FIELD_W-1:0]),
        .adj       (lat_adj),
        .field_out (tc_field)
    );

    // Reassemble the ordinary-mode word.
    always_comb ord_word = {ord_sec, ord_ns};

    // Reassemble the transparent word; the bits above the field pass through.
    generate
        if (TC_UPPER_W > 0) begin : g_tc_upper
            always_comb tc_word = {ts_time[TIME_W-1:TC_FIELD_W], tc_field};
        end else begin : g_tc_full
            always_comb tc_word = tc_field;
        end
    endgenerate

    // Pick the result for the mode of this word.
    always_comb next_word = (mode == MODE_TRANSPARENT) ? tc_word : ord_word;

    ts_adj_outreg #(
        .DATA_W (TIME_W)
    ) u_outreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_valid (ts_valid),
        .d       (next_word),
        .q_valid (res_valid),
        .q       (res_time)
    );

endmodule

// File: rtl/ts_onestep_adjust_chk.sv
// Module: ts_onestep_adjust_chk
// Property checker bound to ts_onestep_adjust with the default widths.
module ts_onestep_adjust_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ts_valid,
    input logic        transparent,
    input logic [79:0] ts_time,
    input logic        res_valid,
    input logic [79:0] res_time
);
    // R2: an accepted word yields a valid result on the next cycle.
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ts_valid |=> res_valid);

    // R2: no result without an accepted word.
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_valid |=> !res_valid);

    // R9: the result holds while no word is accepted.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_valid |=> $stable(res_time));

    // R8: pass-through bits in transparent mode.
    p_tc_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_valid && transparent) |=> (res_time[79:63] == $past(ts_time[79:63])));

    // R5: legal nanoseconds stay legal after adjustment.
    p_ns_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_valid && !transparent && (ts_time[31:0] < 32'd1000000000))
        |=> (res_time[31:0] < 32'd1000000000));

    // R5: seconds either stay or advance by exactly one.
    p_sec_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_valid && !transparent)
        |=> ((res_time[79:32] == $past(ts_time[79:32])) ||
             (res_time[79:32] == 48'($past(ts_time[79:32]) + 48'd1))));

endmodule

bind ts_onestep_adjust ts_onestep_adjust_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ts_valid    (ts_valid),
    .transparent (transparent),
    .ts_time     (ts_time),
    .res_valid   (res_valid),
    .res_time    (res_time)
);

// File: tb/ts_onestep_adjust_bench.sv
`timescale 1ns/1ps
module ts_onestep_adjust_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ts_valid = 1'b0;
    logic        transparent = 1'b0;
    logic [79:0] ts_time = '0;
    logic [10:0] lat_adj = '0;
    logic        res_valid;
    logic [79:0] res_time;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    ts_onestep_adjust u_ts_onestep_adjust (
        .clk (clk), .rst_n (rst_n), .ts_valid (ts_valid),
        .transparent (transparent), .ts_time (ts_time), .lat_adj (lat_adj),
        .res_valid (res_valid), .res_time (res_time)
    );

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected ordinary-mode result, from R3..R6.
    function automatic logic [79:0] exp_ord(input logic [79:0] t, input logic [10:0] a);
        logic [63:0] ns;
        logic [47:0] sec;
        ns  = 64'(t[31:0]) + 64'(a[10:3]);
        sec = t[79:32];
        if (ns >= 64'd1000000000) begin
            ns  = ns - 64'd1000000000;
            sec = sec + 48'd1;
        end
        return {sec, ns[31:0]};
    endfunction

    // Expected transparent-mode result, from R7 and R8.
    function automatic logic [79:0] exp_tc(input logic [79:0] t, input logic [10:0] a);
        logic [63:0] f;
        f = 64'(t[62:0]) + 64'(a) * 64'd8192;
        return {t[79:63], f[62:0]};
    endfunction

    // Apply one word, sample the registered result one cycle later.
    task automatic apply(input string req, input logic m, input logic [79:0] t,
                         input logic [10:0] a);
        logic [79:0] e;
        e = m ? exp_tc(t, a) : exp_ord(t, a);
        @(negedge clk);
        ts_valid = 1'b1; transparent = m; ts_time = t; lat_adj = a;
        @(negedge clk);
        ts_valid = 1'b0;
        check({req, " valid"}, 80'(res_valid), 80'd1);
        check(req, res_time, e);
    endtask

    task automatic t_reset();
        check("R1 valid", 80'(res_valid), 80'd0);
        check("R1 time", res_time, 80'd0);
    endtask

    task automatic t_ordinary();
        apply("R3 small", 1'b0, {48'd5, 32'd100}, {8'd20, 3'd0});
        apply("R3 mid", 1'b0, {48'h1234_5678_9ABC, 32'd500000000}, {8'd255, 3'd0});
        apply("R5 edge_no_roll", 1'b0, {48'd7, 32'd999999744}, {8'd255, 3'd0});
    endtask

    task automatic t_fraction();
        apply("R4 frac0", 1'b0, {48'd9, 32'd123456}, {8'd3, 3'd0});
        apply("R4 frac7", 1'b0, {48'd9, 32'd123456}, {8'd3, 3'd7});
        check("R4 frac7 absolute", res_time, {48'd9, 32'd123459});
    endtask

    task automatic t_rollover();
        apply("R5 exact", 1'b0, {48'd41, 32'd999999990}, {8'd10, 3'd5});
        check("R5 exact absolute", res_time, {48'd42, 32'd0});
        apply("R5 past", 1'b0, {48'd41, 32'd999999999}, {8'd255, 3'd0});
        check("R5 past absolute", res_time, {48'd42, 32'd254});
    endtask

    task automatic t_sec_wrap();
        apply("R6 wrap", 1'b0, {48'hFFFF_FFFF_FFFF, 32'd999999999}, {8'd1, 3'd0});
        check("R6 wrap absolute", res_time, 80'd0);
    endtask

    task automatic t_transparent();
        apply("R7 plain", 1'b1, {17'h0, 47'd1000, 16'h0000}, {8'd2, 3'd4});
        check("R7 plain absolute", res_time, {17'h0, 47'd1002, 16'h8000});
        apply("R7 frac_carry", 1'b1, {17'h0, 47'd50, 16'hE000}, {8'd0, 3'd1});
        check("R7 frac_carry absolute", res_time, {17'h0, 47'd51, 16'h0000});
        apply("R8 upper", 1'b1, {17'h1_5A5A, 47'h7FFF_FFFF_FFFF, 16'hF000}, {8'd255, 3'd7});
        check("R8 upper absolute", {63'd0, res_time[79:63]}, {63'd0, 17'h1_5A5A});
    endtask

    task automatic t_hold();
        logic [79:0] kept;
        apply("R9 load", 1'b0, {48'd3, 32'd77}, {8'd1, 3'd0});
        kept = res_time;
        @(negedge clk);
        transparent = 1'b1; ts_time = {80{1'b1}}; lat_adj = 11'h7FF;
        @(negedge clk);
        check("R9 hold valid", 80'(res_valid), 80'd0);
        check("R9 hold", res_time, kept);
    endtask

    task automatic t_mode_switch();
        logic [79:0] ta, tb;
        ta = {48'd11, 32'd999999999};
        tb = {17'h0ABC, 47'd999999999, 16'h0000};
        @(negedge clk);
        ts_valid = 1'b1; transparent = 1'b0; ts_time = ta; lat_adj = {8'd1, 3'd0};
        @(negedge clk);
        transparent = 1'b1; ts_time = tb;
        check("R10 first", res_time, exp_ord(ta, {8'd1, 3'd0}));
        @(negedge clk);
        ts_valid = 1'b0;
        check("R10 second", res_time, exp_tc(tb, {8'd1, 3'd0}));
        check("R2 second valid", 80'(res_valid), 80'd1);
        @(negedge clk);
        check("R2 drop", 80'(res_valid), 80'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_ordinary();
        t_fraction();
        t_rollover();
        t_sec_wrap();
        t_transparent();
        t_hold();
        t_mode_switch();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule